// File: doc/BRIEF.md
# Tiled Surface Address Swizzler

This block turns a pixel position on a two-dimensional surface into the byte address of that pixel. The caller supplies a base address, the row pitch in bytes, the size of one pixel in bytes, the pixel column and row, a layout select and a bit-6 swizzle select. The block handles three layouts:
- a plain row-major linear layout;
- a tiled layout with wide, shallow 4 KB tiles (8 rows of 512 bytes);
- a tiled layout with narrow, tall 4 KB tiles (32 rows of 128 bytes, stored as 16-byte columns).

For tiled surfaces, address bit 6 inside the tile can be XOR-folded with a chosen set of bits 9, 10 and 11. This spreads neighbouring rows over different cache sets.

The path is one register deep. A request presented with `in_valid` appears on the outputs one clock later with `out_valid` set. An illegal layout code, or an illegal swizzle code on a tiled surface, raises `out_err` and forces the address to zero. It does not produce a guessed address. The block has no state machine. Its only state is the output register stage, which loads on a valid request and otherwise holds.

Top module: `tile_addr_swizzler`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low in the cycle after an edge at which it was low. The result of a request is therefore visible exactly one cycle after it is presented.
- R2: While `rst_n` is low, `out_valid`, `out_err` and `out_addr` are all zero.
- R3: With `tile_mode` = 0 (linear), the address is `base + y*pitch + x*cpp`. The swizzle select is ignored, including codes 5 to 7, and no error is raised.
- R4: With `tile_mode` = 1 (wide tiles), let byte column c = x*cpp. The address is `base + (c/512)*4096 + (y/8)*pitch*8 + off`, where the in-tile offset is `off = (y%8)*512 + c%512` before swizzling.
- R5: With `tile_mode` = 2 (tall tiles), let c = x*cpp. The address is `base + (c/128)*4096 + (y/32)*pitch*32 + off`, where `off = ((c%128)/16)*512 + (y%32)*16 + c%16` before swizzling.
- R6: Swizzle code 0 leaves the in-tile offset unchanged.
- R7: Swizzle code 1 replaces offset bit 6 with bit6 XOR bit9.
- R8: Swizzle code 2 replaces offset bit 6 with bit6 XOR bit9 XOR bit10.
- R9: Swizzle code 3 replaces offset bit 6 with bit6 XOR bit9 XOR bit11.
- R10: Swizzle code 4 replaces offset bit 6 with bit6 XOR bit9 XOR bit10 XOR bit11. In every swizzle code, no offset bit other than bit 6 is altered.
- R11: On a tiled surface, swizzle codes 5, 6 and 7 set `out_err` and give `out_addr` = 0.
- R12: `tile_mode` = 3 sets `out_err` and gives `out_addr` = 0, whatever the swizzle code.
- R13: While `in_valid` is low, `out_addr` and `out_err` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| base_addr | input | ADDR_W | Surface base byte address |
| pitch_bytes | input | PITCH_W | Row pitch in bytes (a multiple of the tile width) |
| pix_bytes | input | CPP_W | Bytes per pixel |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel row |
| tile_mode | input | 2 | 0 linear, 1 wide tiles, 2 tall tiles, 3 illegal |
| swz_mode | input | 3 | 0 none, 1 bit9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11, 5-7 illegal |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_addr | output | ADDR_W | Byte address, zero on error |
| out_err | output | 1 | Illegal layout or swizzle code |

## Verification
The bench walks every tile row (0 to 7) under each swizzle code, with in-tile column bit 6 both clear and set. This exposes a swizzle that folds the wrong bit, drops bit 11, or disturbs a bit other than 6; any of these gives a wrong address on some row. Tall-tile requests place the column across the 16-byte sub-column boundary and the row across the tile-row boundary. A design that mixed up the two geometries, or used the wrong tile-row stride, would misplace those pixels. Linear requests carry an illegal swizzle code to catch a design that raises a false error. The illegal-code cases and an idle stretch with changing inputs catch, respectively, an address that leaks through on error and an output register that loads without a valid strobe.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [1:0] {
        TM_LINEAR = 2'd0,
        TM_WIDE   = 2'd1,
        TM_TALL   = 2'd2,
        TM_BAD    = 2'd3
    } tile_mode_e;

    typedef enum logic [2:0] {
        SW_NONE     = 3'd0,
        SW_B9       = 3'd1,
        SW_B9_10    = 3'd2,
        SW_B9_11    = 3'd3,
        SW_B9_10_11 = 3'd4
    } swz_mode_e;

    localparam int TILE_LOG2 = 12;   // 4 KB tile
    localparam int OFF_W     = TILE_LOG2;

endpackage

// File: rtl/tsw_tile_geom.sv
module tsw_tile_geom
    import tsw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int COORD_W = 14,
    parameter int CPP_W   = 4,
    parameter bit TALL    = 1'b0
) (
    input  logic [PITCH_W-1:0] pitch_bytes,
    input  logic [CPP_W-1:0]   pix_bytes,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic [ADDR_W-1:0]  tile_base,
    output logic [OFF_W-1:0]   tile_off
);
    localparam int COL_LOG2  = TALL ? 7 : 9;   // tile width in bytes, log2
    localparam int ROWS_LOG2 = TALL ? 5 : 3;   // tile height in rows, log2
    localparam int BC_W      = COORD_W + CPP_W;

    logic [BC_W-1:0]   byte_col;
    logic [ADDR_W-1:0] tile_col_a;
    logic [ADDR_W-1:0] tile_row_a;
    logic [ADDR_W-1:0] pitch_a;

    always_comb begin
        byte_col   = {{CPP_W{1'b0}}, pix_x} * {{COORD_W{1'b0}}, pix_bytes};
        tile_col_a = ADDR_W'(byte_col >> COL_LOG2);
        tile_row_a = ADDR_W'(pix_y >> ROWS_LOG2);
        pitch_a    = ADDR_W'(pitch_bytes);
        tile_base  = (tile_col_a << TILE_LOG2)
                   + ((tile_row_a * pitch_a) << ROWS_LOG2);
    end

    generate
        if (TALL) begin : g_tall
            // 16-byte column index above, row in tile, byte within column
            assign tile_off = {byte_col[6:4], pix_y[4:0], byte_col[3:0]};
        end else begin : g_wide
            // row in tile above, byte within 512-byte row
            assign tile_off = {pix_y[2:0], byte_col[8:0]};
        end
    endgenerate

endmodule

// File: rtl/tsw_bit6_swizzle.sv
module tsw_bit6_swizzle
    import tsw_pkg::*;
(
    input  logic [OFF_W-1:0] off_in,
    input  logic [2:0]       swz_mode,
    output logic [OFF_W-1:0] off_out,
    output logic             bad_code
);
    logic flip;

    always_comb begin
        flip     = 1'b0;
        bad_code = 1'b0;
        case (swz_mode)
            SW_NONE:     flip = 1'b0;
            SW_B9:       flip = off_in[9];
            SW_B9_10:    flip = off_in[9] ^ off_in[10];
            SW_B9_11:    flip = off_in[9] ^ off_in[11];
            SW_B9_10_11: flip = off_in[9] ^ off_in[10] ^ off_in[11];
            default:     bad_code = 1'b1;
        endcase
        off_out    = off_in;
        off_out[6] = off_in[6] ^ flip;
    end

    // R10: only bit 6 may differ between input and output offset
    always_comb begin
        if (!$isunknown({off_in, swz_mode}))
            p_only_bit6_r10: assert (((off_in ^ off_out) & ~OFF_W'(64)) == '0);
    end

    // R6: code 0 is the identity
    always_comb begin
        if (!$isunknown({off_in, swz_mode}) && swz_mode == 3'd0)
            p_none_identity_r6: assert (off_out == off_in);
    end

endmodule

// File: rtl/tile_addr_swizzler.sv
module tile_addr_swizzler
    import tsw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int COORD_W = 14,
    parameter int CPP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [PITCH_W-1:0] pitch_bytes,
    input  logic [CPP_W-1:0]   pix_bytes,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [1:0]         tile_mode,
    input  logic [2:0]         swz_mode,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_err
);
    logic [ADDR_W-1:0] wide_base, tall_base, sel_base, lin_addr, nxt_addr;
    logic [OFF_W-1:0]  wide_off, tall_off, sel_off, swz_off;
    logic              swz_bad, nxt_err;

    tsw_tile_geom #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .COORD_W(COORD_W),
        .CPP_W(CPP_W), .TALL(1'b0)
    ) u_wide (
        .pitch_bytes(pitch_bytes), .pix_bytes(pix_bytes),
        .pix_x(pix_x), .pix_y(pix_y),
        .tile_base(wide_base), .tile_off(wide_off)
    );

    tsw_tile_geom #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .COORD_W(COORD_W),
        .CPP_W(CPP_W), .TALL(1'b1)
    ) u_tall (
        .pitch_bytes(pitch_bytes), .pix_bytes(pix_bytes),
        .pix_x(pix_x), .pix_y(pix_y),
        .tile_base(tall_base), .tile_off(tall_off)
    );

    assign sel_base = (tile_mode == TM_TALL) ? tall_base : wide_base;
    assign sel_off  = (tile_mode == TM_TALL) ? tall_off  : wide_off;

    tsw_bit6_swizzle u_swz (
        .off_in(sel_off), .swz_mode(swz_mode),
        .off_out(swz_off), .bad_code(swz_bad)
    );

    always_comb begin
        lin_addr = base_addr
                 + ADDR_W'(pix_y) * ADDR_W'(pitch_bytes)
                 + ADDR_W'(pix_x) * ADDR_W'(pix_bytes);
        nxt_err  = 1'b0;
        nxt_addr = '0;
        unique case (tile_mode)
            TM_LINEAR: nxt_addr = lin_addr;
            TM_WIDE, TM_TALL: begin
                nxt_err = swz_bad;
                if (!swz_bad)
                    nxt_addr = base_addr + sel_base + ADDR_W'(swz_off);
            end
            default: nxt_err = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= nxt_addr;
                out_err  <= nxt_err;
            end
        end
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_linear_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tile_mode == 2'd0) |=> !out_err);
    p_bad_tile_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tile_mode == 2'd3) |=> (out_err && out_addr == '0));
    p_err_zero_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_addr == '0);
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_addr) && $stable(out_err)));

endmodule

// File: tb/tile_addr_swizzler_tb.sv
module tile_addr_swizzler_tb;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] pitch_bytes = '0;
    logic [3:0]  pix_bytes = '0;
    logic [13:0] pix_x = '0;
    logic [13:0] pix_y = '0;
    logic [1:0]  tile_mode = '0;
    logic [2:0]  swz_mode = '0;
    logic        out_valid, out_err;
    logic [31:0] out_addr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    tile_addr_swizzler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .base_addr(base_addr), .pitch_bytes(pitch_bytes), .pix_bytes(pix_bytes),
        .pix_x(pix_x), .pix_y(pix_y), .tile_mode(tile_mode), .swz_mode(swz_mode),
        .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
    );

    function automatic longint swz_fix(longint off, int sm);
        longint b9  = (off / 512) % 2;
        longint b10 = (off / 1024) % 2;
        longint b11 = (off / 2048) % 2;
        longint f;
        case (sm)
            1: f = b9;
            2: f = (b9 + b10) % 2;
            3: f = (b9 + b11) % 2;
            4: f = (b9 + b10 + b11) % 2;
            default: f = 0;
        endcase
        if (f == 1) begin
            if ((off / 64) % 2 == 1) return off - 64;
            else return off + 64;
        end
        return off;
    endfunction

    function automatic longint model(longint b, longint p, longint c, longint x,
                                     longint y, int tm, int sm);
        longint bc = x * c;
        longint off;
        if (tm == 0) return (b + y * p + bc) % (64'd1 << 32);
        if (tm == 1) begin
            off = (y % 8) * 512 + bc % 512;
            return (b + (bc / 512) * 4096 + (y / 8) * p * 8 + swz_fix(off, sm)) % (64'd1 << 32);
        end
        off = ((bc % 128) / 16) * 512 + (y % 32) * 16 + bc % 16;
        return (b + (bc / 128) * 4096 + (y / 32) * p * 32 + swz_fix(off, sm)) % (64'd1 << 32);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request, sample one cycle later away from the edge
    task automatic issue(logic [31:0] b, logic [15:0] p, logic [3:0] c,
                         logic [13:0] x, logic [13:0] y, logic [1:0] tm, logic [2:0] sm);
        @(negedge clk);
        base_addr = b; pitch_bytes = p; pix_bytes = c;
        pix_x = x; pix_y = y; tile_mode = tm; swz_mode = sm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_ok(string req, logic [31:0] b, logic [15:0] p, logic [3:0] c,
                             logic [13:0] x, logic [13:0] y, logic [1:0] tm, logic [2:0] sm);
        issue(b, p, c, x, y, tm, sm);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " err"}, {31'd0, out_err}, 32'd0);
        chk({req, " addr"}, out_addr, 32'(model(b, p, c, x, y, int'(tm), int'(sm))));
    endtask

    task automatic t_reset;
        chk("R2 valid", {31'd0, out_valid}, 32'd0);
        chk("R2 err", {31'd0, out_err}, 32'd0);
        chk("R2 addr", out_addr, 32'd0);
    endtask

    task automatic t_linear;
        expect_ok("R3 lin a", 32'h0004_0000, 16'd1920, 4'd4, 14'd33, 14'd7, 2'd0, 3'd0);
        expect_ok("R3 lin b", 32'h1000_0000, 16'd640, 4'd2, 14'd319, 14'd479, 2'd0, 3'd7);
        expect_ok("R3 lin c", 32'h0000_0100, 16'd4096, 4'd1, 14'd5, 14'd0, 2'd0, 3'd5);
    endtask

    task automatic t_wide;
        expect_ok("R4 wide a", 32'h0001_0000, 16'd2048, 4'd4, 14'd200, 14'd13, 2'd1, 3'd0);
        expect_ok("R4 wide b", 32'h0020_0000, 16'd4096, 4'd2, 14'd1000, 14'd71, 2'd1, 3'd0);
        expect_ok("R4 wide c", 32'h0, 16'd512, 4'd1, 14'd511, 14'd8, 2'd1, 3'd0);
    endtask

    task automatic t_tall;
        expect_ok("R5 tall a", 32'h0003_0000, 16'd1024, 4'd4, 14'd37, 14'd45, 2'd2, 3'd0);
        expect_ok("R5 tall b", 32'h0, 16'd512, 4'd1, 14'd127, 14'd31, 2'd2, 3'd0);
        expect_ok("R5 tall c", 32'h0, 16'd512, 4'd1, 14'd128, 14'd32, 2'd2, 3'd0);
        expect_ok("R5 tall swz", 32'h0, 16'd256, 4'd1, 14'd112, 14'd3, 2'd2, 3'd4);
    endtask

    task automatic t_swizzle;
        string tags[5] = '{"R6", "R7", "R8", "R9", "R10"};
        for (int sm = 0; sm < 5; sm++) begin
            for (int row = 0; row < 8; row++) begin
                for (int col = 0; col < 2; col++) begin
                    expect_ok(tags[sm], 32'h0008_0000, 16'd1024, 4'd1,
                              14'(col * 64 + 5), 14'(row), 2'd1, 3'(sm));
                end
            end
        end
    endtask

    task automatic t_bad_codes;
        for (int sm = 5; sm < 8; sm++) begin
            issue(32'h1234_0000, 16'd1024, 4'd4, 14'd9, 14'd9, 2'd1, 3'(sm));
            chk("R11 err", {31'd0, out_err}, 32'd1);
            chk("R11 addr", out_addr, 32'd0);
        end
        issue(32'h1234_0000, 16'd1024, 4'd4, 14'd9, 14'd9, 2'd2, 3'd6);
        chk("R11 tall err", {31'd0, out_err}, 32'd1);
        issue(32'h5555_0000, 16'd1024, 4'd4, 14'd9, 14'd9, 2'd3, 3'd0);
        chk("R12 err", {31'd0, out_err}, 32'd1);
        chk("R12 addr", out_addr, 32'd0);
        chk("R12 valid", {31'd0, out_valid}, 32'd1);
    endtask

    task automatic t_hold;
        logic [31:0] ref_addr;
        expect_ok("R13 setup", 32'h0000_4000, 16'd2048, 4'd4, 14'd17, 14'd3, 2'd1, 3'd2);
        ref_addr = out_addr;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            base_addr = 32'hFFFF_0000 + 32'(i);
            tile_mode = 2'd3;
            pix_x = 14'(i * 77);
            chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
            chk("R13 addr hold", out_addr, ref_addr);
            chk("R13 err hold", {31'd0, out_err}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_linear;
        t_wide;
        t_tall;
        t_swizzle;
        t_bad_codes;
        t_hold;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule